// File: doc/BRIEF.md
# Dependency-Driven Task Dispatcher

This block hands out work to a pool of worker cores according to a task graph that is written into it before it starts. Each table row gives a task's predecessor set, its urgency, an instance count, and an optional wait on an external software event. Once `run` is raised, the block finds the tasks that may start, picks the most urgent one, and offers it to a free core as a (task id, instance number) pair. The core keeps that work until it reports completion.

A duplicable task is offered once per instance, and its instances may run together on different cores. Its successors are held back until every instance has reported completion. The block releases a task that waits on an event when that event number pulses. It steers work away from cores whose enable bit is low, so it keeps running when some cores are missing. A summary flag shows that the whole graph has finished. A sticky flag records completion reports that do not match an assignment.

Top module: `tg_sched`

## Requirements
- R1: After reset, no dispatch is offered on any core, and `all_done` and `err` are low.
- R2: A loaded task may start only when every task whose bit is set in its predecessor mask has completed all of its instances. Bit j of the mask stands for task j. A task that was never loaded counts as completed.
- R3: A task whose wait flag is set may start only after a pulse on bit `ld_evt` of `sw_evt`. The pulse may arrive before `run` and is remembered. A pulse on an event number that no task waits on changes nothing.
- R4: Among tasks that may start, the one with the larger priority value is chosen. On equal priority the lower task index wins.
- R5: A free core is chosen lowest index first, and at most one new offer is made per clock cycle. The offer appears on the core's dispatch port in the cycle after the edge where the choice was made.
- R6: A core whose `core_en` bit is low is never given a new offer.
- R7: An offer holds its valid, task id and instance number stable until `disp_ready` is seen. After that, the core stays busy and gets nothing else until it sends a done report.
- R8: A task with quota q is offered q times, with instance numbers 0 to q-1 in ascending order. A quota of 0 is loaded as 1. The task completes when q done reports for it have arrived.
- R9: `all_done` is high while `run` is high and every loaded task has completed.
- R10: A done report for a core that is not busy, or whose offer is still waiting for `disp_ready`, sets `err`. `err` stays set until reset, and the report changes no other state.
- R11: A core freed by a done report can take a new offer at the next edge. A done report on one core and a new offer to another core may happen on the same edge.
- R12: Table writes made while `run` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Dispatch enable; table writes are accepted only while low |
| core_en | input | NC | Per-core enable mask |
| ld_we | input | 1 | Table row write strobe |
| ld_id | input | TW | Task index of the row being written |
| ld_preds | input | NT | Predecessor mask, bit j = task j |
| ld_prio | input | PW | Priority, larger value is more urgent |
| ld_quota | input | QW | Instance count, 0 read as 1 |
| ld_wait | input | 1 | Task waits for a software event |
| ld_evt | input | EW | Event number waited on |
| sw_evt | input | NE | Software event pulses, one bit per event |
| disp_valid | output | NC | Per-core offer valid |
| disp_ready | input | NC | Per-core offer accept |
| disp_task | output | NC*TW | Per-core task id, core c at bits [c*TW +: TW] |
| disp_inst | output | NC*QW | Per-core instance number, core c at bits [c*QW +: QW] |
| done_valid | input | 1 | One-cycle completion report |
| done_core | input | CW | Core index of the completion report |
| all_done | output | 1 | Whole graph has completed |
| err | output | 1 | Sticky mismatched-completion flag |

## Verification
The case of interest is a completion report on one core landing on the same edge as a new offer to a different core. The bench frees one core, so that the edge after it offers a newly released task to that core. On that same edge it reports completion from a second core. It then checks that the first offer goes to the lowest free core, and that the second core takes the next instance on the very next edge. A second case, a done report arriving while an offer is still waiting for `disp_ready`, is checked by requiring that `err` is set while the offer stays intact.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // index of the lowest set bit; 0 when no bit is set
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/tg_pick.sv
module tg_pick #(
  parameter int NT = 8,
  parameter int PW = 3,
  parameter int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0]    rdy,
  input  logic [NT*PW-1:0] prio,
  output logic             hit,
  output logic [TW-1:0]    id
);
  logic [PW-1:0] best;

  // strict compare keeps the lower index on equal priority
  always_comb begin
    hit  = 1'b0;
    id   = '0;
    best = '0;
    for (int i = 0; i < NT; i++) begin
      if (rdy[i] && (!hit || prio[i*PW +: PW] > best)) begin
        hit  = 1'b1;
        id   = TW'(i);
        best = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/tg_slot.sv
module tg_slot #(
  parameter int TW = 3,
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          set,
  input  logic [TW-1:0] set_tsk,
  input  logic [QW-1:0] set_inst,
  input  logic          take,
  input  logic          fin,
  output logic          valid,
  output logic          busy,
  output logic [TW-1:0] tsk,
  output logic [QW-1:0] inst
);
  logic          valid_n, busy_n;
  logic [TW-1:0] tsk_n;
  logic [QW-1:0] inst_n;

  always_comb begin
    valid_n = valid;
    busy_n  = busy;
    tsk_n   = tsk;
    inst_n  = inst;
    if (valid && take) valid_n = 1'b0;
    if (fin)           busy_n  = 1'b0;
    if (set) begin
      valid_n = 1'b1;
      busy_n  = 1'b1;
      tsk_n   = set_tsk;
      inst_n  = set_inst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      busy  <= 1'b0;
      tsk   <= '0;
      inst  <= '0;
    end else begin
      valid <= valid_n;
      busy  <= busy_n;
      tsk   <= tsk_n;
      inst  <= inst_n;
    end
  end

  AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> (en && !busy)); // R6
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(tsk) && $stable(inst))); // R7
  AST_BUSY_UNTIL_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy); // R7
endmodule

// File: rtl/tg_sched.sv
module tg_sched #(
  parameter int NT = 8,
  parameter int NC = 4,
  parameter int NE = 4,
  parameter int PW = 3,
  parameter int QW = 3,
  parameter int TW = (NT > 1) ? $clog2(NT) : 1,
  parameter int CW = (NC > 1) ? $clog2(NC) : 1,
  parameter int EW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NC-1:0]    core_en,
  input  logic             ld_we,
  input  logic [TW-1:0]    ld_id,
  input  logic [NT-1:0]    ld_preds,
  input  logic [PW-1:0]    ld_prio,
  input  logic [QW-1:0]    ld_quota,
  input  logic             ld_wait,
  input  logic [EW-1:0]    ld_evt,
  input  logic [NE-1:0]    sw_evt,
  output logic [NC-1:0]    disp_valid,
  input  logic [NC-1:0]    disp_ready,
  output logic [NC*TW-1:0] disp_task,
  output logic [NC*QW-1:0] disp_inst,
  input  logic             done_valid,
  input  logic [CW-1:0]    done_core,
  output logic             all_done,
  output logic             err
);
  import tg_pkg::*;

  // task table and progress state
  logic [NT-1:0] loaded_q, wait_q, seen_q, cmpl_q;
  logic [NT-1:0] loaded_n, wait_n, seen_n, cmpl_n;
  logic [NT-1:0] preds_q [NT];
  logic [NT-1:0] preds_n [NT];
  logic [PW-1:0] prio_q  [NT];
  logic [PW-1:0] prio_n  [NT];
  logic [QW-1:0] quota_q [NT];
  logic [QW-1:0] quota_n [NT];
  logic [EW-1:0] evt_q   [NT];
  logic [EW-1:0] evt_n   [NT];
  logic [QW-1:0] launch_q [NT];
  logic [QW-1:0] launch_n [NT];
  logic [QW-1:0] fin_q   [NT];
  logic [QW-1:0] fin_n   [NT];
  logic          err_n;

  logic [NT-1:0]    sat, rdy;
  logic [NT*PW-1:0] prio_flat;
  logic             hit, go, done_ok;
  logic [TW-1:0]    pick_id, done_tsk;
  logic [NC-1:0]    busy, free, set, fin;
  logic [CW-1:0]    sel_core;
  logic [TW-1:0]    slot_tsk  [NC];
  logic [QW-1:0]    slot_inst [NC];

  always_comb begin
    sat = cmpl_q | ~loaded_q;
    for (int t = 0; t < NT; t++) begin
      rdy[t] = run && loaded_q[t] && ((preds_q[t] & ~sat) == '0) &&
               (!wait_q[t] || seen_q[t]) && (launch_q[t] < quota_q[t]);
      prio_flat[t*PW +: PW] = prio_q[t];
    end
  end

  tg_pick #(.NT(NT), .PW(PW), .TW(TW)) u_pick (
    .rdy(rdy), .prio(prio_flat), .hit(hit), .id(pick_id)
  );

  always_comb begin
    free     = core_en & ~busy;
    sel_core = CW'(lowest_set(32'(free)));
    go       = hit && (free != '0);
    done_ok  = done_valid && (32'(done_core) < NC) &&
               busy[done_core] && !disp_valid[done_core];
    done_tsk = slot_tsk[done_core];
    for (int c = 0; c < NC; c++) begin
      set[c] = go && (sel_core == CW'(c));
      fin[c] = done_ok && (done_core == CW'(c));
    end
  end

  generate
    for (genvar c = 0; c < NC; c++) begin : g_core
      tg_slot #(.TW(TW), .QW(QW)) u_slot (
        .clk(clk), .rst_n(rst_n), .en(core_en[c]),
        .set(set[c]), .set_tsk(pick_id), .set_inst(launch_q[pick_id]),
        .take(disp_ready[c]), .fin(fin[c]),
        .valid(disp_valid[c]), .busy(busy[c]),
        .tsk(slot_tsk[c]), .inst(slot_inst[c])
      );
      assign disp_task[c*TW +: TW] = slot_tsk[c];
      assign disp_inst[c*QW +: QW] = slot_inst[c];
    end
  endgenerate

  // next state
  always_comb begin
    loaded_n = loaded_q;
    wait_n   = wait_q;
    cmpl_n   = cmpl_q;
    preds_n  = preds_q;
    prio_n   = prio_q;
    quota_n  = quota_q;
    evt_n    = evt_q;
    launch_n = launch_q;
    fin_n    = fin_q;
    err_n    = err_q_or(err, done_valid && !done_ok);
    seen_n   = seen_q;
    for (int t = 0; t < NT; t++) begin
      if (wait_q[t] && sw_evt[evt_q[t]]) seen_n[t] = 1'b1;
    end
    if (go) launch_n[pick_id] = launch_q[pick_id] + 1'b1;
    if (done_ok) begin
      fin_n[done_tsk] = fin_q[done_tsk] + 1'b1;
      if (fin_q[done_tsk] + 1'b1 == quota_q[done_tsk]) cmpl_n[done_tsk] = 1'b1;
    end
    if (ld_we && !run) begin
      loaded_n[ld_id] = 1'b1;
      preds_n[ld_id]  = ld_preds;
      prio_n[ld_id]   = ld_prio;
      quota_n[ld_id]  = (ld_quota == '0) ? QW'(1) : ld_quota;
      wait_n[ld_id]   = ld_wait;
      evt_n[ld_id]    = ld_evt;
      seen_n[ld_id]   = 1'b0;
      launch_n[ld_id] = '0;
      fin_n[ld_id]    = '0;
      cmpl_n[ld_id]   = 1'b0;
    end
  end

  function automatic logic err_q_or(input logic a, input logic b);
    return a | b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      wait_q   <= '0;
      seen_q   <= '0;
      cmpl_q   <= '0;
      err      <= 1'b0;
      for (int t = 0; t < NT; t++) begin
        preds_q[t]  <= '0;
        prio_q[t]   <= '0;
        quota_q[t]  <= '0;
        evt_q[t]    <= '0;
        launch_q[t] <= '0;
        fin_q[t]    <= '0;
      end
    end else begin
      loaded_q <= loaded_n;
      wait_q   <= wait_n;
      seen_q   <= seen_n;
      cmpl_q   <= cmpl_n;
      err      <= err_n;
      preds_q  <= preds_n;
      prio_q   <= prio_n;
      quota_q  <= quota_n;
      evt_q    <= evt_n;
      launch_q <= launch_n;
      fin_q    <= fin_n;
    end
  end

  assign all_done = run && (&sat);

  generate
    for (genvar t = 0; t < NT; t++) begin : g_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        launch_q[t] <= quota_q[t]); // R8
    end
  endgenerate
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> (busy == '0)); // R9
endmodule

// File: tb/tb_tg_sched.sv
module tb_tg_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8, NC = 4, NE = 4, PW = 3, QW = 3, TW = 3, CW = 2, EW = 2;

  // row: {id, preds, prio, quota, wait, evt}
  localparam logic [19:0] P1 [5] = '{
    {3'd0, 8'h00, 3'd1, 3'd1, 1'b0, 2'd0},
    {3'd1, 8'h00, 3'd5, 3'd1, 1'b0, 2'd0},
    {3'd2, 8'h01, 3'd2, 3'd3, 1'b0, 2'd0},
    {3'd3, 8'h06, 3'd3, 3'd1, 1'b0, 2'd0},
    {3'd4, 8'h00, 3'd7, 3'd1, 1'b1, 2'd2}
  };
  localparam logic [19:0] P2 [2] = '{
    {3'd0, 8'h00, 3'd0, 3'd2, 1'b0, 2'd0},
    {3'd1, 8'h01, 3'd7, 3'd0, 1'b0, 2'd0}
  };

  logic clk, rst_n, run, ld_we, ld_wait, done_valid, all_done, err;
  logic [NC-1:0] core_en, disp_valid, disp_ready;
  logic [TW-1:0] ld_id;
  logic [NT-1:0] ld_preds;
  logic [PW-1:0] ld_prio;
  logic [QW-1:0] ld_quota;
  logic [EW-1:0] ld_evt;
  logic [NE-1:0] sw_evt;
  logic [NC*TW-1:0] disp_task;
  logic [NC*QW-1:0] disp_inst;
  logic [CW-1:0] done_core;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  tg_sched dut (
    .clk(clk), .rst_n(rst_n), .run(run), .core_en(core_en),
    .ld_we(ld_we), .ld_id(ld_id), .ld_preds(ld_preds), .ld_prio(ld_prio),
    .ld_quota(ld_quota), .ld_wait(ld_wait), .ld_evt(ld_evt), .sw_evt(sw_evt),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_task(disp_task),
    .disp_inst(disp_inst), .done_valid(done_valid), .done_core(done_core),
    .all_done(all_done), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic offer(input string req, input int c, input int t, input int i);
    chk(req, 32'(disp_valid), 32'(1 << c));
    chk(req, 32'(disp_task[c*TW +: TW]), 32'(t));
    chk(req, 32'(disp_inst[c*QW +: QW]), 32'(i));
  endtask

  task automatic load_row(input logic [19:0] r);
    ld_we = 1'b1;
    {ld_id, ld_preds, ld_prio, ld_quota, ld_wait, ld_evt} = r;
    tick();
    ld_we = 1'b0;
  endtask

  task automatic done_pulse(input int c);
    done_valid = 1'b1;
    done_core  = CW'(c);
    tick();
    done_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0; ld_id = '0; ld_preds = '0;
    ld_prio = '0; ld_quota = '0; ld_wait = 1'b0; ld_evt = '0; sw_evt = '0;
    core_en = 4'b1011; disp_ready = 4'b1111; done_valid = 1'b0; done_core = '0;
    tick(); tick();
    chk("R1 valid", 32'(disp_valid), 0);
    chk("R1 all_done", 32'(all_done), 0);
    chk("R1 err", 32'(err), 0);
    rst_n = 1'b1;
    tick();

    // phase 1: table walked from the vector array
    for (int k = 0; k < 5; k++) load_row(P1[k]);
    sw_evt = 4'b0010; tick(); sw_evt = '0;        // R3 unused event
    run = 1'b1; tick();
    offer("R4 priority pick", 0, 1, 0);
    tick();
    offer("R5 lowest free core", 1, 0, 0);
    tick();
    chk("R3 waiting task held", 32'(disp_valid), 0);
    sw_evt = 4'b0100; tick(); sw_evt = '0;
    chk("R3 one edge to latch", 32'(disp_valid), 0);
    tick();
    offer("R6 disabled core skipped", 3, 4, 0);
    tick();
    done_pulse(1);                                 // T0 completes
    done_pulse(0);                                 // same edge as T2 offer
    offer("R11 offer with done same edge", 1, 2, 0);
    tick();
    offer("R11 freed core reused", 0, 2, 1);
    tick();
    chk("R7 all busy", 32'(disp_valid), 0);
    done_pulse(3); tick();
    offer("R8 third instance", 3, 2, 2);
    tick();
    done_pulse(1); done_pulse(0); tick();
    chk("R2 partial quota blocks", 32'(disp_valid), 0);
    chk("R9 not yet done", 32'(all_done), 0);
    done_pulse(3); tick();
    offer("R2 successor released", 0, 3, 0);
    tick();
    done_pulse(0);
    chk("R9 graph complete", 32'(all_done), 1);
    chk("R10 no error yet", 32'(err), 0);
    done_pulse(2);
    chk("R10 idle done flags", 32'(err), 1);
    chk("R10 state untouched", 32'(all_done), 1);
    tick();
    chk("R10 sticky", 32'(err), 1);
    chk("R10 no offer", 32'(disp_valid), 0);

    // phase 2: backpressure, quota 0, writes during run
    rst_n = 1'b0; run = 1'b0; tick();
    chk("R1 valid again", 32'(disp_valid), 0);
    chk("R1 err cleared", 32'(err), 0);
    rst_n = 1'b1; core_en = 4'b0001; disp_ready = 4'b0000; tick();
    for (int k = 0; k < 2; k++) load_row(P2[k]);
    run = 1'b1;
    ld_we = 1'b1; {ld_id, ld_preds, ld_prio, ld_quota, ld_wait, ld_evt} =
      {3'd5, 8'h00, 3'd7, 3'd1, 1'b0, 2'd0};
    tick(); ld_we = 1'b0;
    offer("R5 first offer", 0, 0, 0);
    tick(); tick();
    offer("R7 held without ready", 0, 0, 0);
    done_pulse(0);
    chk("R10 done while pending", 32'(err), 1);
    offer("R10 offer intact", 0, 0, 0);
    disp_ready = 4'b0001; tick();
    chk("R7 accepted", 32'(disp_valid), 0);
    tick();
    chk("R7 busy core gets nothing", 32'(disp_valid), 0);
    done_pulse(0); tick();
    offer("R8 second instance", 0, 0, 1);
    tick();
    done_pulse(0); tick();
    offer("R8 quota zero task", 0, 1, 0);
    tick();
    done_pulse(0);
    chk("R12 late write ignored", 32'(all_done), 1);
    tick();
    chk("R8 single instance for quota 0", 32'(disp_valid), 0);

    ended = 1;
    summary();
    $finish;
  end
endmodule